// File: doc/BRIEF.md
# Column Draw Command Queue

This block is the command front end of a column-based rasterizer. A processor builds each draw command from two 32-bit register writes. The first write only stages a word. The second write supplies the descriptor word and commits the pair. Segments whose first and last row are equal are dropped at the door, unless they are tagged as the end of a column. Kept commands wait in a deep FIFO.

A dispatcher takes entries from the head of the FIFO whenever the external segment drawer is idle. An ordinary segment starts the drawer. The drawer receives both command words in the same cycle as its start pulse, and it sees them unchanged until it releases busy. An end-of-column entry starts the external column sender, but only once that sender is idle. At the same moment it flips a ping-pong select over a column buffer that holds twice the screen height. From then on, the drawer fills one half while the sender streams out the other.

Register map: the second word (commit) is at address `(1<<16) | (1<<2)`, and the first word is at the same address plus 1. Every other address bit must be zero for either register to respond. The descriptor word carries these fields: texture id in bits [7:0], end-of-column flag in bit 9, first row in bits [17:10] and last row in bits [25:18]. A queue entry holds the first word in bits [63:32] and the descriptor in bits [31:0].

Top module: `colcmd_queue`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, both start pulses are 0, `drw_buf_base`=0 and `snd_buf_base`=SCREEN_H.
- R2: A write to the first-word register never adds a queue entry.
- R3: A commit write with first row ≠ last row queues `{first word, descriptor}`. When that entry is dispatched, `drw_start` pulses for one cycle with `drw_word_hi`/`drw_word_lo` equal to the two words.
- R4: A commit with first row = last row and bit 9 clear is discarded and starts nothing.
- R5: A commit with bit 9 set is queued even when its rows are equal. On dispatch it pulses `snd_start` and never `drw_start`.
- R6: In a cycle where a commit write is accepted, no entry is dispatched.
- R7: While `drw_busy` is 1 nothing is dispatched. Entries are dispatched in write order.
- R8: An end-of-column entry at the head waits while `snd_busy` is 1. Entries behind it are not drawn until it leaves.
- R9: Each end-of-column dispatch swaps the halves: `drw_buf_base` alternates 0/SCREEN_H, and `snd_buf_base` is always the other half.
- R10: After DEPTH kept commands with no dispatch, `q_full`=1. A further commit is ignored.
- R11: A write to any address other than the two registers has no effect.
- R12: The drawer words stay stable while `drw_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 17 | Write address |
| bus_wdata | input | 32 | Write data |
| drw_busy | input | 1 | Segment drawer busy; must rise the cycle after `drw_start` |
| snd_busy | input | 1 | Column sender busy; must rise the cycle after `snd_start` |
| drw_start | output | 1 | One-cycle start pulse to drawer |
| drw_word_hi | output | 32 | First command word to drawer |
| drw_word_lo | output | 32 | Descriptor word to drawer |
| drw_buf_base | output | 9 | Column buffer half being drawn |
| snd_start | output | 1 | One-cycle start pulse to sender |
| snd_buf_base | output | 9 | Column buffer half being streamed |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |

## Verification
A commit write and a dispatch can both want the same cycle. The commit wins, and the waiting entry goes out one cycle later. To provoke this, the bench holds the drawer busy while a command is queued. It then releases busy in the very cycle that presents a second commit. The bench samples `drw_start` inside that cycle and expects 0. In the following cycle it expects the first command's words on the drawer port.

// File: rtl/colcmd_pkg.sv
`timescale 1ns/1ps
package colcmd_pkg;
  localparam int WORD_W   = 32;
  localparam int TEX_LSB  = 0;
  localparam int EOC_BIT  = 9;
  localparam int ROW_W    = 8;
  localparam int ROW0_LSB = 10;
  localparam int ROW1_LSB = 18;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } cmd_t;

  function automatic logic is_eoc(input logic [WORD_W-1:0] w);
    return w[EOC_BIT];
  endfunction

  function automatic logic is_empty_seg(input logic [WORD_W-1:0] w);
    return w[ROW0_LSB +: ROW_W] == w[ROW1_LSB +: ROW_W];
  endfunction
endpackage

// File: rtl/colcmd_decode.sv
`timescale 1ns/1ps
module colcmd_decode
  import colcmd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int REGION_BIT = 16,
  parameter int WORD_IDX   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              push_req,
  output cmd_t              push_cmd
);
  localparam logic [ADDR_W-1:0] A_COMMIT =
    (ADDR_W'(1) << REGION_BIT) | (ADDR_W'(WORD_IDX) << 2);
  localparam logic [ADDR_W-1:0] A_STAGE = A_COMMIT | ADDR_W'(1);

  logic              hit_stage, hit_commit;
  logic [WORD_W-1:0] stage_q, stage_d;

  always_comb begin
    hit_stage  = bus_we && (bus_addr == A_STAGE);
    hit_commit = bus_we && (bus_addr == A_COMMIT);
    stage_d    = hit_stage ? bus_wdata : stage_q;
    push_req   = hit_commit && (!is_empty_seg(bus_wdata) || is_eoc(bus_wdata));
    push_cmd   = '{hi: stage_q, lo: bus_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/colcmd_fifo.sv
`timescale 1ns/1ps
module colcmd_fifo
  import colcmd_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t wdata,
  input  logic pop,
  output cmd_t head,
  output logic empty,
  output logic full
);
  localparam int AW = $clog2(DEPTH);

  cmd_t        mem [DEPTH];
  logic [AW:0] wr_q, rd_q, wr_d, rd_d;
  logic        push_ok, pop_ok;

  always_comb begin
    empty   = (wr_q == rd_q);
    full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wr_d    = push_ok ? wr_q + 1'b1 : wr_q;
    rd_d    = pop_ok  ? rd_q + 1'b1 : rd_q;
    head    = mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/colcmd_dispatch.sv
`timescale 1ns/1ps
module colcmd_dispatch
  import colcmd_pkg::*;
#(
  parameter int SCREEN_H = 200,
  parameter int CB_AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              q_empty,
  input  cmd_t              head,
  input  logic              drw_busy,
  input  logic              snd_busy,
  output logic              pop,
  output logic              drw_start,
  output logic              snd_start,
  output logic [WORD_W-1:0] drw_word_hi,
  output logic [WORD_W-1:0] drw_word_lo,
  output logic [CB_AW-1:0]  drw_buf_base,
  output logic [CB_AW-1:0]  snd_buf_base
);
  localparam logic [CB_AW-1:0] HALF = CB_AW'(SCREEN_H);

  cmd_t hold_q, hold_d;
  logic sel_q, sel_d;
  logic may_go;

  always_comb begin
    may_go    = !push_req && !q_empty && !drw_busy;
    drw_start = may_go && !is_eoc(head.lo);
    snd_start = may_go &&  is_eoc(head.lo) && !snd_busy;
    pop       = drw_start || snd_start;
    hold_d    = drw_start ? head : hold_q;
    sel_d     = sel_q ^ snd_start;
    drw_word_hi  = hold_d.hi;
    drw_word_lo  = hold_d.lo;
    drw_buf_base = sel_q ? HALF : '0;
    snd_buf_base = sel_q ? '0 : HALF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/colcmd_queue.sv
`timescale 1ns/1ps
module colcmd_queue
  import colcmd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int REGION_BIT = 16,
  parameter int WORD_IDX   = 1,
  parameter int DEPTH      = 256,
  parameter int SCREEN_H   = 200,
  parameter int CB_AW      = $clog2(2 * SCREEN_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              drw_busy,
  input  logic              snd_busy,
  output logic              drw_start,
  output logic [31:0]       drw_word_hi,
  output logic [31:0]       drw_word_lo,
  output logic [CB_AW-1:0]  drw_buf_base,
  output logic              snd_start,
  output logic [CB_AW-1:0]  snd_buf_base,
  output logic              q_empty,
  output logic              q_full
);
  logic [1:0] rst_sync;
  logic       rst_i_n;
  logic       push_req, pop;
  cmd_t       push_cmd, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  colcmd_decode #(.ADDR_W(ADDR_W), .REGION_BIT(REGION_BIT), .WORD_IDX(WORD_IDX)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .push_req(push_req), .push_cmd(push_cmd)
  );

  colcmd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(push_req), .wdata(push_cmd),
    .pop(pop), .head(head), .empty(q_empty), .full(q_full)
  );

  colcmd_dispatch #(.SCREEN_H(SCREEN_H), .CB_AW(CB_AW)) u_disp (
    .clk(clk), .rst_n(rst_i_n), .push_req(push_req), .q_empty(q_empty),
    .head(head), .drw_busy(drw_busy), .snd_busy(snd_busy), .pop(pop),
    .drw_start(drw_start), .snd_start(snd_start),
    .drw_word_hi(drw_word_hi), .drw_word_lo(drw_word_lo),
    .drw_buf_base(drw_buf_base), .snd_buf_base(snd_buf_base)
  );
endmodule

// File: rtl/colcmd_queue_chk.sv
`timescale 1ns/1ps
module colcmd_queue_chk #(
  parameter int ADDR_W     = 17,
  parameter int REGION_BIT = 16,
  parameter int WORD_IDX   = 1,
  parameter int CB_AW      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              drw_busy,
  input logic              snd_busy,
  input logic              drw_start,
  input logic [31:0]       drw_word_hi,
  input logic [31:0]       drw_word_lo,
  input logic [CB_AW-1:0]  drw_buf_base,
  input logic              snd_start,
  input logic              q_empty,
  input logic              q_full
);
  localparam logic [ADDR_W-1:0] A_COMMIT =
    (ADDR_W'(1) << REGION_BIT) | (ADDR_W'(WORD_IDX) << 2);
  logic commit_kept;
  assign commit_kept = bus_we && (bus_addr == A_COMMIT) &&
                       ((bus_wdata[17:10] != bus_wdata[25:18]) || bus_wdata[9]);

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drw_start && snd_start));
  assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_kept |-> (!drw_start && !snd_start));
  assert_drawer_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drw_busy |-> (!drw_start && !snd_start));
  assert_sender_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snd_busy |-> !snd_start);
  assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snd_start |=> (drw_buf_base != $past(drw_buf_base)));
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
  assert_nothing_from_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (!drw_start && !snd_start));
  assert_words_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drw_busy |-> ($stable(drw_word_hi) && $stable(drw_word_lo)));
endmodule

bind colcmd_queue colcmd_queue_chk #(
  .ADDR_W(ADDR_W), .REGION_BIT(REGION_BIT), .WORD_IDX(WORD_IDX), .CB_AW(CB_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .drw_busy(drw_busy), .snd_busy(snd_busy),
  .drw_start(drw_start), .drw_word_hi(drw_word_hi), .drw_word_lo(drw_word_lo),
  .drw_buf_base(drw_buf_base), .snd_start(snd_start),
  .q_empty(q_empty), .q_full(q_full)
);

// File: tb/sim_colcmd_queue.sv
`timescale 1ns/1ps
module sim_colcmd_queue;
  localparam int H = 200;
  localparam logic [16:0] A_W1 = 17'h10004;
  localparam logic [16:0] A_W0 = 17'h10005;
  // {kind(0 none,1 draw,2 send), first word, descriptor}
  localparam logic [65:0] VEC [7] = '{
    {2'd1, 32'hA0000001, 32'h00A01403},
    {2'd0, 32'h11111111, 32'h001C1C09},
    {2'd2, 32'h00000000, 32'h00000200},
    {2'd1, 32'hDEADBEEF, 32'h00031CFF},
    {2'd2, 32'h12345678, 32'h00282A01},
    {2'd0, 32'hFFFFFFFF, 32'h03FFFC55},
    {2'd1, 32'h0F0F0F0F, 32'h00040000}
  };

  logic        clk, rst_n, bus_we, drw_hold, snd_hold;
  logic [16:0] bus_addr;
  logic [31:0] bus_wdata, drw_word_hi, drw_word_lo;
  logic        drw_busy, snd_busy, drw_start, snd_start, q_empty, q_full;
  logic [8:0]  drw_buf_base, snd_buf_base;
  int          checks, errors, dn, sn, dcnt, scnt;
  logic [63:0] dlog [512];
  logic        exp_sel;

  colcmd_queue u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .drw_busy(drw_busy), .snd_busy(snd_busy),
    .drw_start(drw_start), .drw_word_hi(drw_word_hi), .drw_word_lo(drw_word_lo),
    .drw_buf_base(drw_buf_base), .snd_start(snd_start),
    .snd_buf_base(snd_buf_base), .q_empty(q_empty), .q_full(q_full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign drw_busy = drw_hold || (dcnt != 0);
  assign snd_busy = snd_hold || (scnt != 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= 0; scnt <= 0; dn <= 0; sn <= 0;
    end else begin
      if (drw_start) begin
        dcnt <= 3; dlog[dn[8:0]] <= {drw_word_hi, drw_word_lo}; dn <= dn + 1;
      end else if (dcnt != 0) dcnt <= dcnt - 1;
      if (snd_start) begin
        scnt <= 2; sn <= sn + 1;
      end else if (scnt != 0) scnt <= scnt - 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bases(input string req);
    check(drw_buf_base == (exp_sel ? 9'(H) : 9'd0), req, 64'(drw_buf_base),
          exp_sel ? 64'(H) : 64'd0);
    check(snd_buf_base == (exp_sel ? 9'd0 : 9'(H)), req, 64'(snd_buf_base),
          exp_sel ? 64'd0 : 64'(H));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; exp_sel = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    drw_hold = 1'b0; snd_hold = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    check(q_empty && !q_full, "R1 flags", {q_empty, q_full}, 2'b10);
    check(!drw_start && !snd_start, "R1 starts", {drw_start, snd_start}, 0);
    check_bases("R1 bases");

    // Vector walk: R3 draw, R4 discard, R5 end-of-column, R9 swap
    for (int i = 0; i < 7; i++) begin
      int d0, s0;
      d0 = dn; s0 = sn;
      wr(A_W0, VEC[i][63:32]);
      wr(A_W1, VEC[i][31:0]);
      idle(6);
      case (VEC[i][65:64])
        2'd1: begin
          check(dn == d0 + 1, "R3 draw count", 64'(dn), 64'(d0 + 1));
          check(dlog[d0[8:0]] == VEC[i][63:0], "R3 words", dlog[d0[8:0]], VEC[i][63:0]);
        end
        2'd0: check(dn == d0 && sn == s0 && q_empty, "R4 discard",
                    {dn[31:0], sn[31:0]}, {d0[31:0], s0[31:0]});
        default: begin
          exp_sel = ~exp_sel;
          check(sn == s0 + 1 && dn == d0, "R5 send", {dn[31:0], sn[31:0]},
                {d0[31:0], 32'(s0 + 1)});
          check_bases("R9 swap");
        end
      endcase
    end

    // R2: staging write alone queues nothing
    wr(A_W0, 32'hCAFE0001);
    idle(1);
    check(q_empty, "R2 stage only", 64'(q_empty), 1);

    // R11: commits to neighbour addresses are ignored
    begin
      int d0;
      d0 = dn;
      wr(17'h00004, 32'h00A01403);
      wr(17'h10008, 32'h00A01403);
      wr(17'h10006, 32'h00A01403);
      idle(4);
      check(q_empty && dn == d0, "R11 bad address", 64'(dn), 64'(d0));
    end

    // R6 / R7 / R12: commit wins over dispatch; order and stability
    begin
      int d0;
      d0 = dn;
      drw_hold = 1'b1;
      wr(A_W0, 32'hAAAA0000);
      wr(A_W1, 32'h00081000);
      idle(2);
      check(dn == d0 && !q_empty, "R7 busy blocks", 64'(dn), 64'(d0));
      wr(A_W0, 32'hBBBB0000);
      @(negedge clk);
      drw_hold = 1'b0; bus_we = 1'b1; bus_addr = A_W1; bus_wdata = 32'h000C2000;
      #5;
      check(!drw_start, "R6 commit priority", 64'(drw_start), 0);
      @(negedge clk);
      bus_we = 1'b0;
      #5;
      check(drw_start && drw_word_hi == 32'hAAAA0000, "R7 order",
            {31'd0, drw_start, drw_word_hi}, {32'd1, 32'hAAAA0000});
      @(negedge clk);
      #5;
      check(drw_busy && !drw_start && drw_word_hi == 32'hAAAA0000 &&
            drw_word_lo == 32'h00081000, "R12 stable", {drw_word_hi, drw_word_lo},
            {32'hAAAA0000, 32'h00081000});
      idle(8);
      check(dn == d0 + 2 && dlog[9'(d0 + 1)] == {32'hBBBB0000, 32'h000C2000},
            "R7 second", dlog[9'(d0 + 1)], {32'hBBBB0000, 32'h000C2000});
    end

    // R8 / R9: end-of-column waits on busy sender and blocks followers
    begin
      int d0, s0;
      d0 = dn; s0 = sn;
      snd_hold = 1'b1;
      wr(A_W0, 32'h0000C0C0);
      wr(A_W1, 32'h00000200);
      wr(A_W0, 32'h0000D0D0);
      wr(A_W1, 32'h00100400);
      idle(6);
      check(sn == s0 && dn == d0 && !q_empty, "R8 waits",
            {dn[31:0], sn[31:0]}, {d0[31:0], s0[31:0]});
      check_bases("R9 no swap while waiting");
      snd_hold = 1'b0;
      idle(8);
      exp_sel = ~exp_sel;
      check(sn == s0 + 1 && dn == d0 + 1 && dlog[d0[8:0]][63:32] == 32'h0000D0D0,
            "R8 release", dlog[d0[8:0]], {32'h0000D0D0, 32'h00100400});
      check_bases("R9 swap after release");
    end

    // R10: fill to DEPTH, overflow ignored
    begin
      int d0;
      d0 = dn;
      drw_hold = 1'b1;
      for (int k = 0; k < 256; k++) begin
        wr(A_W0, 32'(k));
        wr(A_W1, 32'h00140000 | 32'(k[7:0]));
      end
      idle(1);
      check(q_full && !q_empty, "R10 full", {q_full, q_empty}, 2'b10);
      wr(A_W0, 32'h00000BAD);
      wr(A_W1, 32'h00140077);
      drw_hold = 1'b0;
      idle(256 * 4 + 20);
      check(dn == d0 + 256, "R10 count", 64'(dn), 64'(d0 + 256));
      check(dlog[9'(d0 + 255)] == {32'd255, 32'h001400FF} && q_empty,
            "R10 overflow dropped", dlog[9'(d0 + 255)], {32'd255, 32'h001400FF});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule